// File: doc/BRIEF.md
# Banked ROM Address Mapper Registers

This block is the register set of a cartridge address mapper on an 8-bit CPU bus. Software writes three registers in the $5000–$53FF region. A low bank register holds ROM address bits A18..A15 and an enable for automatic pattern-table switching. A high bank register holds A20..A19. A mode register selects D0/D1 exchange on bank writes and decides whether A16..A15 come from the low bank register or are held at 1. From these registers the block forms a 21-bit ROM address for the 32 KiB window at CPU $8000–$FFFF.

The block also drives the A12 line of an 8 KiB character RAM. When automatic switching is enabled, A12 is taken from video address bit A9, captured when video A13 rises during a video read or write. The result is that the upper and lower halves of each nametable fetch from different 4 KiB pattern tables. Every register clears on reset, so the CPU starts in 32 KiB bank 3.

Top module: `bank_mapper_regs`

## Requirements
- R1: A write lands only when `cpu_wr` is high and `cpu_addr[15:8]` equals $50 (low bank), $52 (high bank) or $53 (mode). It takes effect from the clock edge that samples the strobe. Writes to any other page, including $51 and $54, change no output.
- R2: After reset all registers are zero and `prg_addr[20:15]` reads 6'b000011, which is 32 KiB bank 3.
- R3: In the low bank register, bits 3..0 drive `prg_addr[18:15]` (subject to R8), and bit 7 enables the automatic pattern-table switch.
- R4: In the high bank register, bits 1..0 drive `prg_addr[20:19]`.
- R5: While mode bit 0 is 1, data bits D0 and D1 are exchanged before latching on writes to the low and high bank registers.
- R6: A write to the mode register is latched as given, never exchanged, even while mode bit 0 is 1.
- R7: A change of mode bits leaves the values already latched in both bank registers unchanged.
- R8: While mode bit 2 is 0, `prg_addr[16:15]` is 2'b11. While it is 1, these bits come from low bank bits 1..0.
- R9: `prg_addr[14:0]` equals `cpu_addr[14:0]`, and `prg_sel` equals `cpu_addr[15]`.
- R10: While `ppu_addr[13]` is 1, `chr_a12` equals `ppu_addr[12]`.
- R11: While `ppu_addr[13]` is 0 and auto-switch is off, `chr_a12` equals `ppu_addr[12]`.
- R12: While `ppu_addr[13]` is 0 and auto-switch is on, `chr_a12` shows the captured A9 bit. A capture happens on a clock edge that samples `ppu_addr[13]` at 1 after sampling it at 0 on the previous edge, with `ppu_rd` or `ppu_wr` high. A rise without a strobe leaves the captured bit unchanged. The captured bit clears on reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one clock per write |
| ppu_addr | input | 14 | Video address bus |
| ppu_rd | input | 1 | Video read strobe |
| ppu_wr | input | 1 | Video write strobe |
| prg_addr | output | 21 | ROM address: bank bits A20..A15 over CPU A14..A0 |
| prg_sel | output | 1 | High when the CPU address lies in $8000–$FFFF |
| chr_a12 | output | 1 | Character RAM A12 |

## Verification
Bank writes use data values whose two low bits differ, so an exchanged latch reads differently from a plain one. A mode write sets bit 0 alone, which tells apart a mode register that swaps its own data from one that does not. Toggling the mode bits between bank writes separates retained latches from latches that are re-evaluated, and decoys to pages $51 and $54 expose an over-wide decoder. On the video side, A13 pulses alternate A9 between captures and include rises with no strobe. Each of these separates the edge-triggered capture from a level-following or strobe-blind one.

// File: rtl/bank_mapper_regs.sv
module bank_mapper_regs #(
  parameter logic [7:0] PAGE_LO   = 8'h50,
  parameter logic [7:0] PAGE_HI   = 8'h52,
  parameter logic [7:0] PAGE_MODE = 8'h53
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic        cpu_wr,
  input  logic [13:0] ppu_addr,
  input  logic        ppu_rd,
  input  logic        ppu_wr,
  output logic [20:0] prg_addr,
  output logic        prg_sel,
  output logic        chr_a12
);

  logic [3:0] lo_bank;
  logic       auto_en;
  logic [1:0] hi_bank;
  logic       swap_en;
  logic       pass_low;
  logic       a13_q;
  logic       a9_lat;

  logic wr_lo, wr_hi, wr_mode, a13_rise;
  logic [7:0] wdata;

  assign wr_lo   = cpu_wr && (cpu_addr[15:8] == PAGE_LO);
  assign wr_hi   = cpu_wr && (cpu_addr[15:8] == PAGE_HI);
  assign wr_mode = cpu_wr && (cpu_addr[15:8] == PAGE_MODE);
  assign wdata   = swap_en ? {cpu_data[7:2], cpu_data[0], cpu_data[1]} : cpu_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_bank  <= '0;
      auto_en  <= 1'b0;
      hi_bank  <= '0;
      swap_en  <= 1'b0;
      pass_low <= 1'b0;
    end else begin
      if (wr_lo) begin
        lo_bank <= wdata[3:0];
        auto_en <= wdata[7];
      end
      if (wr_hi)
        hi_bank <= wdata[1:0];
      if (wr_mode) begin
        swap_en  <= cpu_data[0];
        pass_low <= cpu_data[2];
      end
    end
  end

  assign prg_addr = {hi_bank, lo_bank[3:2], pass_low ? lo_bank[1:0] : 2'b11, cpu_addr[14:0]};
  assign prg_sel  = cpu_addr[15];

  assign a13_rise = ppu_addr[13] && !a13_q && (ppu_rd || ppu_wr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a13_q  <= 1'b0;
      a9_lat <= 1'b0;
    end else begin
      a13_q <= ppu_addr[13];
      if (a13_rise)
        a9_lat <= ppu_addr[9];
    end
  end

  assign chr_a12 = (!ppu_addr[13] && auto_en) ? a9_lat : ppu_addr[12];

  AST_BOOT_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> prg_addr[20:15] == 6'd3); // R2
  AST_MODE_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> (swap_en == $past(cpu_data[0])) && (pass_low == $past(cpu_data[2]))); // R6
  AST_LO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && swap_en) |=> lo_bank[1:0] == {$past(cpu_data[0]), $past(cpu_data[1])}); // R5
  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo |=> $stable(lo_bank) && $stable(auto_en)); // R7
  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hi |=> $stable(hi_bank)); // R7
  AST_A9_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !a13_rise |=> $stable(a9_lat)); // R12
  AST_A9_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    a13_rise |=> a9_lat == $past(ppu_addr[9])); // R12

endmodule

// File: tb/tb_bank_mapper_regs.sv
module tb_bank_mapper_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h8000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_wr = 1'b0;
  logic [13:0] ppu_addr = 14'h0000;
  logic        ppu_rd = 1'b0;
  logic        ppu_wr = 1'b0;
  logic [20:0] prg_addr;
  logic        prg_sel;
  logic        chr_a12;

  int total = 0;
  int bad = 0;
  string tag = "R2";

  int m_lo = 0, m_hi = 0, m_mode = 0, m_a9 = 0, m_prev = 0;

  always #4 clk = ~clk;

  bank_mapper_regs dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
    .ppu_addr(ppu_addr), .ppu_rd(ppu_rd), .ppu_wr(ppu_wr),
    .prg_addr(prg_addr), .prg_sel(prg_sel), .chr_a12(chr_a12));

  task automatic model_edge();
    int d, page;
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_mode = 0; m_a9 = 0; m_prev = 0;
    end else begin
      if (cpu_wr) begin
        page = cpu_addr >> 8;
        d = cpu_data;
        if ((m_mode % 2) == 1 && page != 'h53)
          d = (d & 'hFC) | ((d & 1) << 1) | ((d >> 1) & 1);
        if (page == 'h50) m_lo = d;
        else if (page == 'h52) m_hi = d & 3;
        else if (page == 'h53) m_mode = cpu_data;
      end
      if (ppu_addr[13] && m_prev == 0 && (ppu_rd || ppu_wr))
        m_a9 = ppu_addr[9];
      m_prev = ppu_addr[13];
    end
  endtask

  task automatic compare();
    int bank, exp_prg, exp_chr;
    bank = ((m_hi & 3) << 4) | (m_lo & 'hC) | (((m_mode & 4) != 0) ? (m_lo & 3) : 3);
    exp_prg = (bank << 15) | (cpu_addr & 'h7FFF);
    if (ppu_addr[13] || ((m_lo >> 7) & 1) == 0) exp_chr = ppu_addr[12];
    else exp_chr = m_a9;
    total++;
    if (prg_addr !== 21'(exp_prg)) begin
      bad++;
      $display("FAIL %s prg_addr actual=%h expected=%h", tag, prg_addr, 21'(exp_prg));
    end
    total++;
    if (prg_sel !== cpu_addr[15]) begin
      bad++;
      $display("FAIL %s prg_sel actual=%b expected=%b", tag, prg_sel, cpu_addr[15]);
    end
    total++;
    if (chr_a12 !== 1'(exp_chr)) begin
      bad++;
      $display("FAIL %s chr_a12 actual=%b expected=%b", tag, chr_a12, 1'(exp_chr));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    tick();
    cpu_wr = 1'b0; cpu_addr = 16'h8000;
    tick();
  endtask

  task automatic vid(input logic a13, input logic a12, input logic a9, input logic r, input logic w);
    ppu_addr = 14'h0000;
    ppu_addr[13] = a13; ppu_addr[12] = a12; ppu_addr[9] = a9;
    ppu_rd = r; ppu_wr = w;
    tick();
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    rst_n = 1'b1;
    tag = "R2"; tick();
    tag = "R9"; cpu_addr = 16'hABCD; tick(); cpu_addr = 16'h4321; tick(); cpu_addr = 16'h8000;
    tag = "R1"; wr(16'h5100, 8'hFF); wr(16'h54AA, 8'hFF); wr(16'h4F00, 8'h07);
    tag = "R8"; wr(16'h5300, 8'h04);
    tag = "R3"; wr(16'h5012, 8'h0A);
    tag = "R4"; wr(16'h52FF, 8'h03); wr(16'h5200, 8'h02);
    tag = "R6"; wr(16'h5300, 8'h05);
    tag = "R6"; wr(16'h5301, 8'h05);
    tag = "R5"; wr(16'h5000, 8'h01); wr(16'h5200, 8'h01); wr(16'h5000, 8'h06);
    tag = "R7"; wr(16'h5300, 8'h04); wr(16'h5300, 8'h00); wr(16'h5300, 8'h05);
    tag = "R8"; wr(16'h5300, 8'h00); cpu_addr = 16'hFFFF; tick(); cpu_addr = 16'h8000;
    tag = "R11"; wr(16'h5000, 8'h00);
    vid(0, 1, 0, 1, 0); vid(0, 0, 1, 0, 0); vid(1, 0, 1, 1, 0); vid(0, 1, 0, 0, 0);
    tag = "R3"; wr(16'h5000, 8'h80);
    tag = "R12";
    vid(0, 1, 1, 0, 0); vid(1, 0, 1, 1, 0); vid(1, 0, 1, 1, 0);
    vid(0, 0, 0, 1, 0); vid(0, 1, 0, 0, 0);
    vid(1, 1, 0, 0, 0); vid(0, 0, 0, 0, 0);
    vid(1, 0, 0, 0, 1); vid(0, 1, 1, 0, 0);
    vid(1, 1, 1, 1, 0); vid(0, 0, 0, 1, 0);
    tag = "R10"; vid(1, 1, 0, 0, 0); vid(1, 0, 1, 0, 0);
    tag = "R12";
    for (int i = 0; i < 8; i++) begin
      vid(0, i[0], i[1], 0, 0);
      vid(1, i[1], i[0], i[2], !i[2]);
    end
    tag = "R11"; wr(16'h5000, 8'h00); vid(0, 1, 1, 0, 0); vid(0, 0, 1, 0, 0);
    tag = "R2"; rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule